// File: doc/BRIEF.md
# Three-Input Bitwise Ternary Logic Unit

This unit evaluates an arbitrary Boolean function of three inputs at every bit position of a 64-bit word. An 8-bit immediate holds the function's truth table. The three inputs are the current value of the destination register, operand A and operand B. Bit i of the result depends only on bit i of each of the three sources. A single immediate can therefore express any of the 256 three-input functions: XOR-of-three, majority, select, pass-through and the rest.

When the record bit accompanies an operation, the unit also produces a 4-bit condition field. This field compares the signed result with zero and carries a summary-overflow flag that arrives as a plain input. By default a single register stage sits behind the logic, so each operation's result appears one cycle after it is presented.

Top module: `ternlog_unit`

## Requirements
- R1: For every bit i, the result bit equals `tt[idx]` with `idx = {dest_old[i], opa[i], opb[i]}`, where `tt[0]` is the least significant bit of the immediate.
- R2: The old destination bit is the most significant index bit and B is the least significant. Immediate 0xF0 passes `dest_old` through, 0xCC passes `opa` and 0xAA passes `opb`.
- R3: Immediate 0x96 yields `dest_old ^ opa ^ opb`, and 0xE8 yields the bitwise majority of the three.
- R4: All 64 bit positions are evaluated independently, from bit 0 up to bit 63.
- R5: `cond_valid` is high only together with `out_valid`, and only for an operation whose `rec` input was 1.
- R6: While `cond_valid` is low, `cond` reads 4'b0000, so an operation without the record bit writes no condition field.
- R7: The condition field is `cond[3]`=LT, `cond[2]`=GT, `cond[1]`=EQ and `cond[0]`=SO. LT and GT come from a signed compare of the result with zero, and EQ is set for a zero result. Exactly one of LT, GT and EQ is set.
- R8: `cond[0]` copies the `so_in` value that was presented with the operation.
- R9: With `REG_OUT`=1, an operation presented with `in_valid` at a rising edge appears on `out_valid`, `result` and `cond` right after the next edge. No output appears without a request. Reset clears `out_valid`, `cond_valid`, `result` and `cond`.
- R10: Immediate 0x00 yields all zeros and 0xFF yields all ones, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| dest_old | input | 64 | Current destination value (index bit 2) |
| opa | input | 64 | Operand A (index bit 1) |
| opb | input | 64 | Operand B (index bit 0) |
| tt | input | 8 | Truth-table immediate |
| rec | input | 1 | Record bit: request a condition field |
| so_in | input | 1 | Summary-overflow flag to copy into the condition field |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Bitwise function result |
| cond | output | 4 | {LT, GT, EQ, SO} |
| cond_valid | output | 1 | Condition field is written this cycle |

## Verification
Some properties are checked on every cycle: the condition-field rules (one-hot compare flags, EQ matching a zero result, LT matching the sign bit, a quiet field when not recorded) and the latency and gating of the valid signals. Whether each result bit really selects the right truth-table entry, in the right index order, can only be shown by the bench's scenarios. Those scenarios cover named functions, walking single bits across the whole width, and pseudo-random operand mixes compared against a sum-of-minterms model.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  localparam int TT_W  = 8;
  localparam int IDX_W = 3;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_t;

  // Table lookup for one bit position: dest is index MSB, b is index LSB.
  function automatic logic lut_pick(input logic [TT_W-1:0] table_bits,
                                    input logic d, input logic a, input logic b);
    logic [IDX_W-1:0] idx;
    idx = {d, a, b};
    return table_bits[idx];
  endfunction
endpackage

// File: rtl/tlu_lut_bit.sv
module tlu_lut_bit
  import tlu_pkg::*;
(
  input  logic [TT_W-1:0] tt,
  input  logic            d,
  input  logic            a,
  input  logic            b,
  output logic            y
);
  always_comb y = lut_pick(tt, d, a, b);
endmodule

// File: rtl/tlu_cond_gen.sv
module tlu_cond_gen
  import tlu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] value,
  input  logic            so_in,
  output crf_t            crf
);
  logic is_zero;
  logic is_neg;

  always_comb begin
    is_zero = (value == '0);
    is_neg  = value[XLEN-1];
    crf.lt  = is_neg;
    crf.eq  = is_zero;
    crf.gt  = !is_neg && !is_zero;
    crf.so  = so_in;
  end
endmodule

// File: rtl/ternlog_unit.sv
module ternlog_unit
  import tlu_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] dest_old,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [7:0]      tt,
  input  logic            rec,
  input  logic            so_in,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic [3:0]      cond,
  output logic            cond_valid
);
  localparam int CW = $bits(crf_t);

  logic [XLEN-1:0] lut_out;
  crf_t            crf_next;
  logic            rec_fire;
  logic [CW-1:0]   cond_next;

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    tlu_lut_bit u_bit (
      .tt (tt),
      .d  (dest_old[i]),
      .a  (opa[i]),
      .b  (opb[i]),
      .y  (lut_out[i])
    );
  end

  tlu_cond_gen #(.XLEN(XLEN)) u_cond (
    .value (lut_out),
    .so_in (so_in),
    .crf   (crf_next)
  );

  assign rec_fire  = in_valid && rec;
  assign cond_next = rec_fire ? crf_next : '0;

  if (REG_OUT) begin : g_reg
    logic            ov_q;
    logic            cv_q;
    logic [XLEN-1:0] res_q;
    logic [CW-1:0]   cond_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ov_q   <= 1'b0;
        cv_q   <= 1'b0;
        res_q  <= '0;
        cond_q <= '0;
      end else begin
        ov_q   <= in_valid;
        cv_q   <= rec_fire;
        cond_q <= cond_next;
        if (in_valid) res_q <= lut_out;
      end
    end

    assign out_valid  = ov_q;
    assign cond_valid = cv_q;
    assign result     = res_q;
    assign cond       = cond_q;
  end else begin : g_comb
    assign out_valid  = in_valid;
    assign cond_valid = rec_fire;
    assign result     = lut_out;
    assign cond       = cond_next;
  end
endmodule

// File: rtl/ternlog_unit_chk.sv
module ternlog_unit_chk #(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            rec,
  input logic            so_in,
  input logic            out_valid,
  input logic [XLEN-1:0] result,
  input logic [3:0]      cond,
  input logic            cond_valid
);
  AST_CV_NEEDS_OV: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid |-> out_valid); // R5
  AST_COND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_valid |-> (cond == 4'b0000)); // R6
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid |-> ($countones(cond[3:1]) == 1)); // R7
  AST_EQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid |-> (cond[1] == (result == '0))); // R7
  AST_LT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid |-> (cond[3] == result[XLEN-1])); // R7

  if (REG_OUT) begin : g_seq
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R9
    AST_NO_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R9
    AST_REC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !rec) |=> !cond_valid); // R5
    AST_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rec) |=> (cond[0] == $past(so_in))); // R8
  end
endmodule

bind ternlog_unit ternlog_unit_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .rec        (rec),
  .so_in      (so_in),
  .out_valid  (out_valid),
  .result     (result),
  .cond       (cond),
  .cond_valid (cond_valid)
);

// File: tb/ternlog_unit_test.sv
module ternlog_unit_test;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [XLEN-1:0] dest_old = '0;
  logic [XLEN-1:0] opa = '0;
  logic [XLEN-1:0] opb = '0;
  logic [7:0]      tt = '0;
  logic            rec = 1'b0;
  logic            so_in = 1'b0;
  logic            out_valid;
  logic [XLEN-1:0] result;
  logic [3:0]      cond;
  logic            cond_valid;

  int errors = 0;
  int checks = 0;

  typedef struct {
    string           tag;
    logic [XLEN-1:0] res;
    logic [3:0]      cnd;
    logic            cv;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  ternlog_unit #(.XLEN(XLEN), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dest_old(dest_old),
    .opa(opa), .opb(opb), .tt(tt), .rec(rec), .so_in(so_in),
    .out_valid(out_valid), .result(result), .cond(cond), .cond_valid(cond_valid)
  );

  task automatic check(input string tag, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Sum-of-minterms reference model.
  function automatic logic [XLEN-1:0] model(input logic [7:0] t, input logic [XLEN-1:0] d,
                                            input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    logic [XLEN-1:0] acc = '0;
    for (int m = 0; m < 8; m++) begin
      logic [XLEN-1:0] term;
      term = (m[2] ? d : ~d) & (m[1] ? a : ~a) & (m[0] ? b : ~b);
      if (t[m]) acc |= term;
    end
    return acc;
  endfunction

  task automatic drive(input string tag, input logic [7:0] t, input logic [XLEN-1:0] d,
                       input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input logic r, input logic s);
    exp_t e;
    @(posedge clk); #1;
    in_valid = 1'b1; tt = t; dest_old = d; opa = a; opb = b; rec = r; so_in = s;
    e.tag = tag;
    e.res = model(t, d, a, b);
    e.cv  = r;
    if (r) e.cnd = {$signed(e.res) < 0, $signed(e.res) > 0, e.res == '0, s};
    else   e.cnd = 4'b0000;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      in_valid = 1'b0; rec = 1'b0;
    end
  endtask

  // Monitor: pop expected items as results come out.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          check("R9", "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, "result", result, e.res);
          check(e.cv ? "R5" : "R6", "cond_valid", cond_valid, e.cv);
          check(e.cv ? "R7" : "R6", "cond", cond, e.cnd);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [XLEN-1:0] mix(input logic [XLEN-1:0] x);
    logic [XLEN-1:0] y = x;
    y ^= y << 13; y ^= y >> 7; y ^= y << 17;
    return y;
  endfunction

  initial begin
    logic [XLEN-1:0] p, q, r;
    repeat (3) @(posedge clk);
    #1;
    // Reset state (R9)
    check("R9", "reset out_valid", out_valid, 0);
    check("R9", "reset cond_valid", cond_valid, 0);
    check("R9", "reset result", result, 0);
    check("R9", "reset cond", cond, 0);
    @(negedge clk); rst_n = 1'b1;

    p = 64'h0123_4567_89AB_CDEF; q = 64'hF0F0_5A5A_3C3C_9669; r = 64'h8000_0000_FFFF_0001;
    drive("R3", 8'h96, p, q, r, 1'b0, 1'b0);
    drive("R3", 8'hE8, p, q, r, 1'b0, 1'b0);
    drive("R2", 8'hF0, p, q, r, 1'b0, 1'b0);
    drive("R2", 8'hCC, p, q, r, 1'b0, 1'b0);
    drive("R2", 8'hAA, p, q, r, 1'b0, 1'b0);
    drive("R10", 8'h00, p, q, r, 1'b1, 1'b0);
    drive("R10", 8'hFF, p, q, r, 1'b1, 1'b1);
    idle(2);
    // Walking bit across full width (R4): only the position where all three are set.
    for (int i = 0; i < XLEN; i += 9) begin
      logic [XLEN-1:0] w;
      w = 64'd1 << i;
      drive("R4", 8'h80, w | 64'h1, w, w, 1'b0, 1'b0);
    end
    drive("R4", 8'h80, 64'h1 << 63, 64'h1 << 63, 64'h1 << 63, 1'b1, 1'b0);
    // Arbitrary tables on pseudo-random operands (R1)
    for (int k = 0; k < 12; k++) begin
      p = mix(p + 64'd3); q = mix(q ^ p); r = mix(r + q);
      drive("R1", 8'(8'h5B + k * 37), p, q, r, k[0], k[1]);
    end
    idle(1);
    // Condition field: negative, positive, zero; SO both ways (R7, R8)
    drive("R7", 8'hF0, 64'hFFFF_0000_0000_0000, 0, 0, 1'b1, 1'b0);
    drive("R7", 8'hF0, 64'h0000_0000_0000_0042, 0, 0, 1'b1, 1'b0);
    drive("R7", 8'h96, 64'h55, 64'h55, 64'h0, 1'b1, 1'b0);
    drive("R8", 8'hCC, 0, 64'h7, 0, 1'b1, 1'b1);
    drive("R8", 8'hCC, 0, 64'h8000_0000_0000_0000, 0, 1'b1, 1'b1);
    // Record bit low: no condition field (R5, R6)
    drive("R6", 8'hF0, 64'hFFFF_0000_0000_0000, 0, 0, 1'b0, 1'b1);
    drive("R5", 8'hE8, 64'h3, 64'h5, 64'h6, 1'b0, 1'b1);
    idle(4);
    // All expected items consumed and nothing further emitted (R9)
    check("R9", "scoreboard drained", sb.size(), 0);
    check("R9", "idle out_valid", out_valid, 0);
    check("R5", "idle cond_valid", cond_valid, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule